// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block makes the sampling strobe for a serial transmitter and receiver that oversample each bit sixteen times. It divides the system clock by a divisor that has a 16-bit whole part and a 6-bit fraction counted in 1/64 steps. The divisor is therefore the clock frequency over sixteen times the baud rate. The fraction is that divisor's fractional remainder times 64, plus one half, rounded down. For example, an 80 MHz clock at 115200 baud gives a whole part of 43 and a fraction of 26.

Each tick period lasts either the whole part or the whole part plus one cycle. A 6-bit accumulator chooses which one. It adds the fraction at every period start, and each overflow adds one cycle to the period that starts there. Across any 64 periods the cycle count therefore equals the fractional divisor times 64 exactly. The divisor inputs are sampled only at period starts. A period in progress always finishes with the divisor it started with.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset `tick_o` is low. The first period starts at the clock edge that samples `en_i` high with `div_int_i` nonzero while the block is idle. At that edge the accumulator is zero. The first `tick_o` pulse appears int-1 edges later, so it comes int cycles after the starting edge.
- R2: A period starts at the start edge and at every edge that ends a tick. At each period start the 6-bit accumulator adds `div_frac_i` modulo 64. That period lasts `div_int_i` cycles, plus one cycle when the addition overflows.
- R3: With a constant divisor, any 64 consecutive periods total exactly 64*int + frac cycles. For int 43 and frac 26 that is 2778 cycles.
- R4: For a whole part of 2 or more, each tick is high for exactly one cycle.
- R5: The divisor inputs are used only at a period start. A change made in the middle of a period first affects the next period.
- R6: While idle, a whole part of 0 produces no ticks. If the whole part is 0 when a running period ends, that period's tick still occurs and generation then stops.
- R7: When `en_i` is sampled low, `tick_o` stays low from the next cycle on and the accumulator clears. Enabling again restarts exactly as in R1.
- R8: With a whole part of 1 and a fraction of 0, `tick_o` is high on every cycle. Large whole parts, such as 40000 with fraction 63, follow R1 and R2 without truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generation enable |
| div_int_i | input | 16 | Whole part of the divisor; 0 stops generation |
| div_frac_i | input | 6 | Fraction of the divisor in 1/64 units |
| tick_o | output | 1 | One-cycle oversampling strobe |

## Verification
The divisor table covers a fraction of zero, where every period should be equal, and fractions of 1, 17, 26, 32 and 63, which set different overflow patterns. Whole parts of 1 and 2 test the shortest periods, where adding one cycle doubles or nearly doubles the period. Every period is checked against an accumulator model, which shows whether the extra cycles fall at the right positions and not merely in the right number. A 64-period sum then checks the total. Directed cases change the divisor in mid-period, set the whole part to zero while running, and disable then re-enable the block, which shows whether the accumulator restarts from zero.

// File: rtl/baud_frac_pkg.sv
package baud_frac_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } gen_state_e;
endpackage

// File: rtl/baud_frac_acc.sv
module baud_frac_acc #(
  parameter int FracW = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [FracW-1:0] frac_i,
  output logic             carry_o
);
  logic [FracW:0]   sum;
  logic [FracW-1:0] acc_q;

  assign sum     = {1'b0, acc_q} + {1'b0, frac_i};
  assign carry_o = sum[FracW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (step_i) acc_q <= sum[FracW-1:0];
  end

  // window tracker: after 2**FracW steps with one fraction the phase must return
  logic [FracW-1:0] steps_q, start_q, frac_ref_q;
  logic             steady_q, steady_ok;

  assign steady_ok = steady_q && (frac_i == frac_ref_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      steps_q    <= '0;
      start_q    <= '0;
      frac_ref_q <= '0;
      steady_q   <= 1'b0;
    end else if (clr_i) begin
      steps_q  <= '0;
      steady_q <= 1'b0;
    end else if (step_i) begin
      steps_q <= steps_q + 1'b1;
      if (steps_q == '0) begin
        start_q    <= acc_q;
        frac_ref_q <= frac_i;
        steady_q   <= 1'b1;
      end else begin
        steady_q <= steady_ok;
      end
    end
  end

  AST_PHASE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && steps_q == '1 && steady_ok) |=> (acc_q == start_q)); // R3
endmodule

// File: rtl/baud_frac_cnt.sv
module baud_frac_cnt #(
  parameter int CntW = 17
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            load_i,
  input  logic            run_i,
  input  logic [CntW-1:0] reload_i,
  output logic            zero_o
);
  logic [CntW-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (load_i)           cnt_q <= reload_i;
    else if (run_i && !zero_o) cnt_q <= cnt_q - 1'b1;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i && zero_o) |=> zero_o); // R6
endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
  import baud_frac_pkg::*;
#(
  parameter int IntW  = 16,
  parameter int FracW = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [IntW-1:0]  div_int_i,
  input  logic [FracW-1:0] div_frac_i,
  output logic             tick_o
);
  localparam int PerW = IntW + 1;

  gen_state_e      state_q, state_d;
  logic            int_zero, cnt_zero, carry, load, stop, running;
  logic [PerW-1:0] period, reload;

  assign running  = (state_q == ST_RUN);
  assign int_zero = (div_int_i == '0);
  assign tick_o   = running && cnt_zero;

  // period start: leaving idle, or the edge that closes a tick
  assign load = en_i && !int_zero && (!running || cnt_zero);
  assign stop = !en_i || (running && cnt_zero && int_zero);

  assign period = {1'b0, div_int_i} + PerW'(carry);
  assign reload = period - PerW'(1);

  always_comb begin
    state_d = state_q;
    if (stop)      state_d = ST_IDLE;
    else if (load) state_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  baud_frac_acc #(.FracW(FracW)) i_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (stop),
    .step_i  (load),
    .frac_i  (div_frac_i),
    .carry_o (carry)
  );

  baud_frac_cnt #(.CntW(PerW)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (stop),
    .load_i   (load),
    .run_i    (running),
    .reload_i (reload),
    .zero_o   (cnt_zero)
  );

  // period tracker: cycles since the last start against the period chosen there
  logic [PerW-1:0] gap_q, exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
      exp_q <= '0;
    end else if (load) begin
      gap_q <= PerW'(1);
      exp_q <= period;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_PERIOD_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (gap_q == exp_q)); // R2

  AST_NO_TICK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !tick_o); // R7

  AST_ZERO_INT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && int_zero) |=> !tick_o); // R6

  AST_ONE_CYCLE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && en_i && div_int_i > IntW'(1)) |=> !tick_o); // R4
endmodule

// File: tb/test_baud_frac_gen.sv
`timescale 1ns/1ps
module test_baud_frac_gen;
  typedef struct packed {
    logic [15:0] di;
    logic [5:0]  df;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'd43, 6'd26}, '{16'd1, 6'd0},  '{16'd1, 6'd63}, '{16'd2, 6'd1},
    '{16'd5,  6'd32}, '{16'd3, 6'd0},  '{16'd16, 6'd63}, '{16'd7, 6'd17}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [15:0] div_int_i = '0;
  logic [5:0]  div_frac_i = '0;
  logic        tick_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  baud_frac_gen i_baud_frac_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .div_int_i  (div_int_i),
    .div_frac_i (div_frac_i),
    .tick_o     (tick_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts negedges until tick_o is seen high; -1 if the limit passes first
  task automatic wait_tick(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!tick_o && n < limit);
    if (!tick_o) n = -1;
  endtask

  task automatic count_ticks(input int cycles, output int seen);
    seen = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk_i);
      if (tick_o) seen++;
    end
  endtask

  task automatic idle_gap();
    en_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  // en_i was raised at the current negedge; checks latency then nper periods
  task automatic run_seq(input int di, input int df, input int nper, input string req);
    int n, acc, sum, per;
    longint tot;
    wait_tick(di + 2, n);
    check(n == di, "R1", n, di);
    acc = df;
    tot = 0;
    for (int k = 0; k < nper; k++) begin
      sum = acc + df;
      per = di + (sum >> 6);
      acc = sum & 63;
      wait_tick(per + 2, n);
      check(n == per, req, n, per);
      if (k < 64) tot += n;
    end
    if (nper >= 64) check(tot == 64 * di + df, "R3", tot, 64 * di + df);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int n, seen;
    repeat (3) @(negedge clk_i);
    check(tick_o == 1'b0, "R1", tick_o, 0);
    rst_ni = 1'b1;
    div_int_i = 16'd4;
    count_ticks(20, seen);
    check(seen == 0, "R1", seen, 0);

    // table walk: R2 per-period timing, R3 window sums
    for (int v = 0; v < NV; v++) begin
      idle_gap();
      div_int_i  = VECS[v].di;
      div_frac_i = VECS[v].df;
      en_i = 1'b1;
      run_seq(int'(VECS[v].di), int'(VECS[v].df), 128, "R2");
    end

    // R4 tick width
    idle_gap();
    div_int_i = 16'd3; div_frac_i = 6'd0; en_i = 1'b1;
    run_seq(3, 0, 2, "R2");
    @(negedge clk_i);
    check(tick_o == 1'b0, "R4", tick_o, 0);

    // R5 mid-period change
    idle_gap();
    div_int_i = 16'd10; div_frac_i = 6'd0; en_i = 1'b1;
    run_seq(10, 0, 1, "R2");
    repeat (3) @(negedge clk_i);
    div_int_i = 16'd4;
    wait_tick(20, n);
    check(n + 3 == 10, "R5", n + 3, 10);
    wait_tick(20, n);
    check(n == 4, "R5", n, 4);

    // R6 zero whole part while idle, then while running
    idle_gap();
    div_int_i = 16'd0; en_i = 1'b1;
    count_ticks(50, seen);
    check(seen == 0, "R6", seen, 0);
    idle_gap();
    div_int_i = 16'd6; en_i = 1'b1;
    run_seq(6, 0, 1, "R2");
    repeat (2) @(negedge clk_i);
    div_int_i = 16'd0;
    wait_tick(20, n);
    check(n + 2 == 6, "R6", n + 2, 6);
    count_ticks(50, seen);
    check(seen == 0, "R6", seen, 0);

    // R7 disable mid-run and restart from a clear accumulator
    idle_gap();
    div_int_i = 16'd5; div_frac_i = 6'd40; en_i = 1'b1;
    run_seq(5, 40, 3, "R7");
    repeat (2) @(negedge clk_i);
    en_i = 1'b0;
    count_ticks(20, seen);
    check(seen == 0, "R7", seen, 0);
    en_i = 1'b1;
    run_seq(5, 40, 4, "R7");

    // R8 extremes
    idle_gap();
    div_int_i = 16'd1; div_frac_i = 6'd0; en_i = 1'b1;
    wait_tick(3, n);
    check(n == 1, "R8", n, 1);
    count_ticks(10, seen);
    check(seen == 10, "R8", seen, 10);
    idle_gap();
    div_int_i = 16'd40000; div_frac_i = 6'd63; en_i = 1'b1;
    run_seq(40000, 63, 1, "R8");

    idle_gap();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule